// File: doc/BRIEF.md
# Bus-Conflict-Detecting Serial Transmitter

This block sends frames on a shared single-wire bus. Each frame has a start bit, nine data bits sent least significant first, and a stop bit. While a frame is on the wire, the block reads the line back. It compares that level with the bit it is driving, and it raises a latched conflict flag on any disagreement. Bit timing comes from two strobes produced outside the block. The shift strobe launches each bit. The sample strobe marks the point at which the readback is taken. Instead of the sample strobe, the readback point can come from an external one-shot timer. The block starts that timer with a trigger pulse at the beginning of every bit and compares when the timer's underflow pulse returns.

Four static configuration inputs set the behaviour.
- A polarity bit inverts the driven and the read-back levels together, so every comparison is made on logical values.
- A sample-source bit picks either the sample strobe or the timer underflow as the comparison point.
- An auto-off bit makes a conflict clear the transmit enable and abandon the current frame.
- A start-mode bit picks how a frame begins. In clocked mode the frame starts on the next shift strobe once the conditions hold. In edge mode it starts on a logical falling edge of the line, which is the physical falling edge with normal polarity and the rising edge with inverted polarity.

The FSM has four states:
- `ST_IDLE`: the line is at the stop level.
- `ST_START`: the start bit is driven.
- `ST_DATA`: nine data bits are driven, counted by an index.
- `ST_STOP`: the stop bit is driven.

Its transitions are:
- IDLE to START on the start condition.
- START to DATA on the shift strobe.
- DATA to DATA on the shift strobe while bits remain.
- DATA to STOP on the shift strobe after the last data bit.
- STOP to IDLE on the shift strobe.
- Any busy state to IDLE on an abort caused by a conflict under auto-off.

Top module: `bctx_top`

## Requirements
- R1: A frame drives a logical 0 start bit, then `tx_data[0]` through `tx_data[8]` in that order, then a logical 1 stop bit. Each bit lasts from one `sclk_fall` strobe to the next.
- R2: `txd` is the logical bit XOR `cfg_inv`. The idle level is logical 1. `rxd` is XORed with `cfg_inv` before it is compared.
- R3: With `cfg_smp_tmr`=0, the comparison is made on the cycle of a `sclk_rise` strobe while busy, and `tmr_uf` is ignored.
- R4: With `cfg_smp_tmr`=1, the comparison is made on the cycle of a `tmr_uf` pulse while busy, and `sclk_rise` is ignored.
- R5: A mismatch sets `conflict_irq` on the next cycle. The flag then holds until an `irq_clr` strobe, and a new mismatch in the same cycle as the clear takes priority.
- R6: With `cfg_auto_off`=1, a mismatch clears `te` and the FSM returns to IDLE on the next cycle, so `txd` goes to the idle level. While the flag is set, `te_set` has no effect.
- R7: With `cfg_auto_off`=0, a mismatch leaves `te` set and the frame runs to its stop bit.
- R8: `te_set` and `te_clr` set and clear `te`. A transmit is pending after a `tx_load` strobe. With `cfg_edge_start`=0, a `sclk_fall` strobe seen in IDLE while `te` is set and a transmit is pending starts the start bit on the next cycle.
- R9: With `cfg_edge_start`=1, a logical falling edge of `rxd` seen in IDLE while `te` is set and a transmit is pending starts the start bit on the next cycle. In this mode `sclk_fall` never starts a frame.
- R10: In edge mode, an edge that arrives while the start conditions are not met is dropped. Meeting the conditions afterwards does not start a frame until a fresh edge arrives.
- R11: `busy` is 1 from the start bit through the stop bit. Starting a frame consumes the pending transmit, so one `tx_load` yields exactly one frame.
- R12: `tmr_trig` pulses for one cycle on the first cycle of every bit. A full frame gives 11 pulses, and a frame aborted during bit k gives k+1 pulses.
- R13: After reset, `txd` is at the idle level, and `busy`, `te`, `conflict_irq` and `tmr_trig` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_fall | input | 1 | Shift strobe; launches the next bit |
| sclk_rise | input | 1 | Sample strobe for readback in strobe mode |
| tmr_uf | input | 1 | External one-shot timer underflow pulse |
| tmr_trig | output | 1 | One-cycle pulse that starts the external timer at each bit |
| tx_data | input | 9 | Frame data word |
| tx_load | input | 1 | Strobe that captures `tx_data` and marks a transmit pending |
| te_set | input | 1 | Strobe that sets the transmit enable |
| te_clr | input | 1 | Strobe that clears the transmit enable |
| te | output | 1 | Transmit enable state |
| cfg_inv | input | 1 | Line polarity: 1 inverts `txd` and `rxd` |
| cfg_smp_tmr | input | 1 | Readback point: 0 uses the sample strobe, 1 uses the timer underflow |
| cfg_auto_off | input | 1 | 1 makes a conflict clear `te` and abort the frame |
| cfg_edge_start | input | 1 | 0 starts on the shift strobe, 1 starts on a line edge |
| irq_clr | input | 1 | Write-one-to-clear strobe for the conflict flag |
| conflict_irq | output | 1 | Latched bus-conflict flag |
| busy | output | 1 | High while a frame is on the line |
| rxd | input | 1 | Line level read back |
| txd | output | 1 | Line level driven |

## Verification
The assertions take several things for granted about the inputs. `sclk_fall` never arrives in the same cycle as the selected sample pulse. The configuration inputs change only while `busy` is low. `rxd` is already synchronous to `clk`. The stimulus respects all three. It places the shift strobe, the sample strobe and the timer underflow on separate phases of an eight-cycle bit period. It changes the configuration only between frames. It drives `rxd` either as a loopback of `txd`, with a mismatch window it controls, or as a forced level changed away from the active clock edge. The sweep covers all sixteen configurations, a conflict in every bit position, and windows that hit only one of the two sampling points.

// File: rtl/bctx_pkg.sv
package bctx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } bctx_state_e;

endpackage

// File: rtl/bctx_line.sv
// Line front end: strips polarity from the readback and finds logical falling edges.
module bctx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic inv,
    output logic rx_log,
    output logic rx_fall
);

    logic prev_q;

    assign rx_log = rxd ^ inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= rx_log;
    end

    assign rx_fall = prev_q & ~rx_log;

endmodule

// File: rtl/bctx_cmp.sv
// Readback comparator: picks the sampling point and flags a mismatch.
module bctx_cmp (
    input  logic busy,
    input  logic bit_log,
    input  logic rx_log,
    input  logic smp_tmr,
    input  logic sclk_rise,
    input  logic tmr_uf,
    output logic mismatch
);

    logic sample_now;

    always_comb begin
        sample_now = smp_tmr ? tmr_uf : sclk_rise;
        mismatch   = busy & sample_now & (rx_log ^ bit_log);
    end

endmodule

// File: rtl/bctx_fsm.sv
// Frame sequencer: start, data and stop bits, with abort back to idle.
module bctx_fsm
    import bctx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              shift,
    input  logic              abort,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              bit_log,
    output logic              trig
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    bctx_state_e       st_q, st_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              launch;
    logic              trig_q;

    // next state
    always_comb begin
        st_d   = st_q;
        sh_d   = sh_q;
        cnt_d  = cnt_q;
        launch = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_d   = ST_START;
                    sh_d   = data;
                    cnt_d  = '0;
                    launch = 1'b1;
                end
            end
            ST_START: begin
                if (abort) begin
                    st_d = ST_IDLE;
                end else if (shift) begin
                    st_d   = ST_DATA;
                    cnt_d  = '0;
                    launch = 1'b1;
                end
            end
            ST_DATA: begin
                if (abort) begin
                    st_d = ST_IDLE;
                end else if (shift) begin
                    launch = 1'b1;
                    if (cnt_q == LAST) begin
                        st_d = ST_STOP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        sh_d  = sh_q >> 1;
                    end
                end
            end
            ST_STOP: begin
                if (abort || shift) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            cnt_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            sh_q   <= sh_d;
            cnt_q  <= cnt_d;
            trig_q <= launch;
        end
    end

    // outputs
    always_comb begin
        busy = (st_q != ST_IDLE);
        trig = trig_q;
        unique case (st_q)
            ST_START: bit_log = 1'b0;
            ST_DATA:  bit_log = sh_q[0];
            default:  bit_log = 1'b1;
        endcase
    end

    // R12: a frame entered from idle announces its first bit to the timer
    a_r12_trig_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_START && $past(st_q) == ST_IDLE) |-> trig_q);

    // R6: an abort while busy returns to idle on the next cycle
    a_r6_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && st_q != ST_IDLE) |=> (st_q == ST_IDLE));

    // R1: the stop bit is only ever reached from the data bits
    a_r1_stop_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && $past(st_q) != ST_STOP) |-> ($past(st_q) == ST_DATA));

endmodule

// File: rtl/bctx_top.sv
module bctx_top
    import bctx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic              tmr_uf,
    output logic              tmr_trig,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              te_set,
    input  logic              te_clr,
    output logic              te,
    input  logic              cfg_inv,
    input  logic              cfg_smp_tmr,
    input  logic              cfg_auto_off,
    input  logic              cfg_edge_start,
    input  logic              irq_clr,
    output logic              conflict_irq,
    output logic              busy,
    input  logic              rxd,
    output logic              txd
);

    logic              te_q, pend_q, irq_q;
    logic [DATA_W-1:0] data_q;
    logic              rx_log, rx_fall;
    logic              bit_log, fsm_busy, conflict, abort, go;

    bctx_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd    (rxd),
        .inv    (cfg_inv),
        .rx_log (rx_log),
        .rx_fall(rx_fall)
    );

    bctx_cmp u_cmp (
        .busy     (fsm_busy),
        .bit_log  (bit_log),
        .rx_log   (rx_log),
        .smp_tmr  (cfg_smp_tmr),
        .sclk_rise(sclk_rise),
        .tmr_uf   (tmr_uf),
        .mismatch (conflict)
    );

    assign abort = cfg_auto_off & conflict;
    assign go    = ~fsm_busy & te_q & pend_q & (cfg_edge_start ? rx_fall : sclk_fall);

    bctx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .shift  (sclk_fall),
        .abort  (abort),
        .data   (data_q),
        .busy   (fsm_busy),
        .bit_log(bit_log),
        .trig   (tmr_trig)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            te_q   <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (conflict)     irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;

            if (cfg_auto_off && (conflict || irq_q)) te_q <= 1'b0;
            else if (te_set)                         te_q <= 1'b1;
            else if (te_clr)                         te_q <= 1'b0;

            if (tx_load) begin
                pend_q <= 1'b1;
                data_q <= tx_data;
            end else if (go) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign te           = te_q;
    assign conflict_irq = irq_q;
    assign busy         = fsm_busy;
    assign txd          = bit_log ^ cfg_inv;

    // R5: a detected mismatch is latched on the next cycle
    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict_irq);

    // R6: under auto-off a raised flag keeps the enable low
    a_r6_te_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && cfg_auto_off) |=> !te_q);

    // R8: a frame never begins without enable and a pending transmit
    a_r8_start_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_busy) |-> $past(te_q && pend_q));

    // R9: in edge mode a frame begins only after a logical falling edge
    a_r9_edge_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fsm_busy) && cfg_edge_start && $past(cfg_edge_start)) |-> $past(rx_fall));

endmodule

// File: tb/sim_bctx_top.sv
module sim_bctx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_fall = 1'b0, sclk_rise = 1'b0, tmr_uf = 1'b0;
    logic       tmr_trig;
    logic [8:0] tx_data = '0;
    logic       tx_load = 1'b0, te_set = 1'b0, te_clr = 1'b0, te;
    logic       cfg_inv = 1'b0, cfg_smp_tmr = 1'b0, cfg_auto_off = 1'b0, cfg_edge_start = 1'b0;
    logic       irq_clr = 1'b0, conflict_irq, busy, txd, rxd;
    logic       rx_ovr = 1'b0, rx_ovr_val = 1'b1, flip = 1'b0;
    logic       count_en = 1'b0;
    int         trig_cnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    assign rxd = rx_ovr ? rx_ovr_val : (txd ^ flip);

    bctx_top #(.DATA_W(9)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
        .tmr_uf(tmr_uf), .tmr_trig(tmr_trig), .tx_data(tx_data), .tx_load(tx_load),
        .te_set(te_set), .te_clr(te_clr), .te(te), .cfg_inv(cfg_inv),
        .cfg_smp_tmr(cfg_smp_tmr), .cfg_auto_off(cfg_auto_off),
        .cfg_edge_start(cfg_edge_start), .irq_clr(irq_clr),
        .conflict_irq(conflict_irq), .busy(busy), .rxd(rxd), .txd(txd)
    );

    always @(negedge clk) if (count_en && tmr_trig) trig_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic fbit(input int p, input logic [8:0] d);
        if (p == 0) return 1'b0;
        if (p == 10) return 1'b1;
        return d[p-1];
    endfunction

    // one frame; conflict window in bit cb (-1 none), phases lo..hi of the bit period
    task automatic run_frame(input int cb, input int lo, input int hi, input logic [8:0] d);
        int  sp;
        bit  exp_conf, abrt, live;
        sp       = cfg_smp_tmr ? 6 : 4;
        exp_conf = (cb >= 0) && (sp >= lo) && (sp <= hi);
        abrt     = exp_conf && cfg_auto_off;
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        te_set = 1'b1; tx_load = 1'b1; tx_data = d; cyc();
        te_set = 1'b0; tx_load = 1'b0;
        chk("R8 enable set", te, 1);
        chk("R5 flag cleared", conflict_irq, 0);
        if (cfg_edge_start) begin
            rx_ovr = 1'b1; rx_ovr_val = 1'b1 ^ cfg_inv;
            cyc(); cyc();
            sclk_fall = 1'b1; cyc(); sclk_fall = 1'b0;
            cyc(); cyc(); cyc();
            chk("R9 shift strobe does not start in edge mode", busy, 0);
        end
        trig_cnt = 0; count_en = 1'b1;
        for (int p = 0; p < 12; p++) begin
            for (int ph = 0; ph < 8; ph++) begin
                sclk_fall = (ph == 0);
                sclk_rise = (ph == 4);
                tmr_uf    = (ph == 6);
                flip      = (p == cb) && (ph >= lo) && (ph <= hi);
                if (cfg_edge_start && p == 0 && ph == 0) rx_ovr_val = 1'b0 ^ cfg_inv;
                if (cfg_edge_start && p == 0 && ph == 1) rx_ovr = 1'b0;
                if (ph == 3) begin
                    live = (p <= 10) && !(abrt && p > cb);
                    chk("R11 busy", busy, int'(live));
                    chk("R1 R2 txd level", txd, int'((live ? fbit(p, d) : 1'b1) ^ cfg_inv));
                    chk("R3 R4 R5 conflict flag", conflict_irq, int'(exp_conf && p > cb));
                    chk("R6 R7 enable", te, int'(!(abrt && p > cb)));
                end
                cyc();
            end
        end
        sclk_fall = 1'b0; sclk_rise = 1'b0; tmr_uf = 1'b0; flip = 1'b0;
        cyc();
        count_en = 1'b0;
        chk("R12 timer triggers", trig_cnt, abrt ? cb + 1 : 11);
        chk("R5 flag held", conflict_irq, int'(exp_conf));
        chk("R6 R7 enable after frame", te, int'(!abrt));
        if (abrt) begin
            te_set = 1'b1; cyc(); te_set = 1'b0;
            chk("R6 te_set ignored while flag set", te, 0);
        end
        if (!cfg_edge_start && !abrt) begin
            sclk_fall = 1'b1; cyc(); sclk_fall = 1'b0; cyc();
            chk("R11 one frame per load", busy, 0);
        end
    endtask

    // edge arriving before the enable is dropped
    task automatic edge_ignored(input logic inv);
        cfg_inv = inv; cfg_smp_tmr = 1'b0; cfg_auto_off = 1'b0; cfg_edge_start = 1'b1;
        cyc();
        irq_clr = 1'b1; te_clr = 1'b1; cyc(); irq_clr = 1'b0; te_clr = 1'b0;
        tx_load = 1'b1; tx_data = 9'h0C3; cyc(); tx_load = 1'b0;
        rx_ovr = 1'b1; rx_ovr_val = 1'b1 ^ inv; cyc(); cyc();
        rx_ovr_val = 1'b0 ^ inv; cyc();
        te_set = 1'b1; cyc(); te_set = 1'b0;
        for (int i = 0; i < 10; i++) begin
            sclk_fall = (i % 4 == 0); cyc();
        end
        sclk_fall = 1'b0;
        chk("R10 stale edge dropped", busy, 0);
        rx_ovr_val = 1'b1 ^ inv; cyc(); cyc();
        rx_ovr_val = 1'b0 ^ inv; cyc(); cyc();
        chk("R9 fresh edge starts", busy, 1);
        for (int i = 0; i < 12 * 4; i++) begin
            sclk_fall = (i % 4 == 0); cyc();
        end
        sclk_fall = 1'b0;
        rx_ovr = 1'b0; cyc();
        chk("R11 frame finished", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(); cyc();
        chk("R13 reset txd idle", txd, 1);
        chk("R13 reset busy", busy, 0);
        chk("R13 reset te", te, 0);
        chk("R13 reset flag", conflict_irq, 0);
        chk("R13 reset trig", tmr_trig, 0);
        rst_n = 1'b1; cyc(); cyc();
        for (int cfg = 0; cfg < 16; cfg++) begin
            cfg_inv        = cfg[0];
            cfg_smp_tmr    = cfg[1];
            cfg_auto_off   = cfg[2];
            cfg_edge_start = cfg[3];
            cyc(); cyc();
            for (int cb = -1; cb <= 10; cb++) begin
                run_frame(cb, 1, 7, 9'((cfg * 73 + (cb + 2) * 29) ^ 9'h155));
            end
            run_frame(3, 4, 5, 9'(cfg * 41 + 9'h0A6));
            run_frame(3, 6, 7, 9'(cfg * 53 + 9'h119));
        end
        edge_ignored(1'b0);
        edge_ignored(1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule